// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Decoder

This block is the device-side control logic of an extended-data-out dynamic RAM, written as a synthesizable behavioural model. A fast system clock samples the active-low row strobe, two per-byte column strobes, write enable and output enable. Each sample is compared with the one before it, and the relative order of strobe edges decides what kind of access is under way. That decision drives a row latch, a column latch, an internal refresh row counter, per-byte write strobes into a small storage array, and a per-byte data output enable.

The block reports the decoded cycle type on a status output, so an environment can compare it against its own classification. It also reports the row refreshed by the most recent row-strobe fall. The read data path follows EDO output-latch rules. Read data stays on the bus after the column strobe rises. It is replaced at the next column-strobe fall. It is released only when both the row strobe and that lane's column strobe are high. Analog timing is not modelled. All strobes are treated as synchronous samples. If the row strobe and a column strobe go low in the same sample, the column strobe counts as earlier.

The data pins are split into a driven output bus, an enable per byte lane, and an input bus. No valid/ready stream is used. The strobes themselves form the transfer protocol, and the block never applies back-pressure: every access completes in the sample in which its strobe edge is seen.

Top module: `edo_dram_ctl`

## Requirements
- R1: A column-strobe fall with the row strobe low and write enable high is a read: cyc_type becomes 1, and after the next edge the lanes whose column strobe is low drive the word stored at {latched row, column pins}, provided output enable is low.
- R2: A column-strobe fall while write enable is already low is an early write: cyc_type becomes 2, the bytes of the falling lanes are stored from din at {latched row, column pins}, and dq_oe stays 0 while cyc_type is 2.
- R3: A write-enable fall while the row strobe and at least one column strobe are low, with output enable high, is a late write: cyc_type becomes 3, and din is stored into the low lanes at the column latched at the column-strobe fall.
- R4: The same write-enable fall with output enable low is a read-modify-write: cyc_type becomes 4. The old data was driven before the fall, the new data is stored, and the bus is released after the fall.
- R5: Lane 0 is din/dout bits 7:0 under cas_n[0], and lane 1 is bits 15:8 under cas_n[1]. A lane is written and driven only through its own column strobe, and the other lane's stored byte is unchanged.
- R6: dq_oe is 0 whenever output enable was high or write enable was low at the previous edge. Raising output enable does not alter the latched read data, so lowering it again drives the same word.
- R7: After a read, a lane keeps driving its data while its column strobe is high and the row strobe is low. It reloads at its next column-strobe fall. It goes high-impedance once the row strobe and its column strobe are both high.
- R8: A column-strobe fall while the row strobe is high sets cyc_type to 7. It writes nothing and drives nothing, even with write enable low.
- R9: A row-strobe fall with both column strobes high sets cyc_type to 5, sets rfsh_row to the address pins, and leaves the bus high-impedance.
- R10: A row-strobe fall with a column strobe already low is a CAS-before-RAS refresh: cyc_type becomes 6 and rfsh_row takes the refresh counter value, ignoring the address pins. The data outputs keep their previous state. rfsh_row changes only on a row-strobe fall.
- R11: The 9-bit refresh counter resets to 0, advances by one when the row strobe rises at the end of each CAS-before-RAS refresh, and wraps after 512.
- R12: After reset, cyc_type is 0 (idle), dq_oe is 0 and rfsh_row is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobes, one per byte lane, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 8*LANES | Write data |
| dout | output | 8*LANES | Read data from the output latches |
| dq_oe | output | LANES | Per-lane output driver enable |
| cyc_type | output | 3 | Decoded cycle type (encoding in R1 to R12) |
| rfsh_row | output | REF_W | Row refreshed at the latest row-strobe fall |

## Verification
The bench builds the block with its defaults: ADDR_W=4 (a 256-word array of 16 rows by 16 columns), REF_W=9 and LANES=2. The small array can be filled completely in page mode before any read, so every randomized read has a known expected word. The full 9-bit refresh counter width lets a loop of 512 CAS-before-RAS cycles reach and pass the wrap point. With two lanes, single-lane reads and writes can show that the other byte stays untouched, and they exercise every dq_oe pattern.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    CT_IDLE  = 3'd0,
    CT_READ  = 3'd1,
    CT_EWR   = 3'd2,
    CT_LWR   = 3'd3,
    CT_RMW   = 3'd4,
    CT_RONLY = 3'd5,
    CT_CBR   = 3'd6,
    CT_CONLY = 3'd7
  } cyc_t;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             oe_q,
  output logic             we_q,
  output logic             ras_fall,
  output logic             ras_rise,
  output logic [LANES-1:0] cas_fall,
  output logic             we_fall
);
  logic             ras_q;
  logic [LANES-1:0] cas_q;

  // previous samples; all strobes idle high in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= '1;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      oe_q  <= oe_n;
    end
  end

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign we_fall  = we_q & ~we_n;
endmodule

// File: rtl/edo_cycle_ctl.sv
module edo_cycle_ctl
  import edo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REF_W  = 9,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic [LANES-1:0]  cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic [LANES-1:0]  cas_fall,
  input  logic              we_fall,
  input  logic              oe_q,
  output cyc_t              cyc_q,
  output logic [REF_W-1:0]  rfsh_row,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] wr_col,
  output logic [LANES-1:0]  wr_en,
  output logic [LANES-1:0]  rd_load,
  output logic              clr_all
);
  logic              in_cbr;
  logic [REF_W-1:0]  ref_cnt;
  logic [ADDR_W-1:0] col_q;

  logic             any_cas_low, cbr_start, page_ok, late_ev, cas_only_ev;
  logic [LANES-1:0] lane_ev, early_ev;

  always_comb begin
    any_cas_low = ~&cas_n;
    cbr_start   = ras_fall & any_cas_low;
    page_ok     = ~ras_n & ~in_cbr & ~ras_fall;
    lane_ev     = cas_fall & {LANES{page_ok}};
    early_ev    = lane_ev & {LANES{~we_n}};
    rd_load     = lane_ev & {LANES{we_n}};
    late_ev     = we_fall & page_ok & any_cas_low & ~|lane_ev;
    cas_only_ev = |cas_fall & ras_n;
    wr_en       = early_ev | (late_ev ? ~cas_n : '0);
    wr_col      = |early_ev ? addr : col_q;
    clr_all     = |wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= CT_IDLE;
      in_cbr   <= 1'b0;
      ref_cnt  <= '0;
      rfsh_row <= '0;
      row_q    <= '0;
      col_q    <= '0;
    end else begin
      if (cbr_start) begin
        in_cbr   <= 1'b1;
        rfsh_row <= ref_cnt;
      end else if (ras_fall) begin
        row_q    <= addr;
        rfsh_row <= REF_W'(addr);
      end
      if (ras_rise && in_cbr) begin
        in_cbr  <= 1'b0;
        ref_cnt <= ref_cnt + REF_W'(1);
      end
      if (|lane_ev) col_q <= addr;
      if (cbr_start)        cyc_q <= CT_CBR;
      else if (ras_fall)    cyc_q <= CT_RONLY;
      else if (|early_ev)   cyc_q <= CT_EWR;
      else if (|rd_load)    cyc_q <= CT_READ;
      else if (late_ev)     cyc_q <= oe_q ? CT_LWR : CT_RMW;
      else if (cas_only_ev) cyc_q <= CT_CONLY;
    end
  end
endmodule

// File: rtl/edo_out_lane.sv
module edo_out_lane
  import edo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              ras_n,
  input  logic              lane_cas_n,
  input  logic              oe_q,
  input  logic              we_q,
  output logic              drive,
  output logic [BYTE_W-1:0] byte_q
);
  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= 1'b0;
      byte_q <= '0;
    end else begin
      if (clr)                      hold <= 1'b0;
      else if (load)                hold <= 1'b1;
      else if (ras_n && lane_cas_n) hold <= 1'b0;
      if (load) byte_q <= rd_byte;
    end
  end

  assign drive = hold & ~oe_q & we_q;
endmodule

// File: rtl/edo_array.sv
module edo_array
  import edo_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [BYTE_W*LANES-1:0] wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [BYTE_W*LANES-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W*LANES-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane_wr
    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[wr_idx][g*BYTE_W +: BYTE_W] <= wr_data[g*BYTE_W +: BYTE_W];
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/edo_dram_ctl.sv
module edo_dram_ctl
  import edo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REF_W  = 9,
  parameter int LANES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic [LANES-1:0]    cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [8*LANES-1:0]  din,
  output logic [8*LANES-1:0]  dout,
  output logic [LANES-1:0]    dq_oe,
  output logic [2:0]          cyc_type,
  output logic [REF_W-1:0]    rfsh_row
);
  localparam int IDX_W = 2 * ADDR_W;

  logic             oe_q, we_q, ras_fall, ras_rise, we_fall, clr_all;
  logic [LANES-1:0] cas_fall, wr_en, rd_load;
  logic [ADDR_W-1:0] row_q, wr_col;
  logic [8*LANES-1:0] rd_data;
  cyc_t             cyc_q;

  edo_strobe_edges #(.LANES(LANES)) u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .oe_q(oe_q), .we_q(we_q), .ras_fall(ras_fall),
    .ras_rise(ras_rise), .cas_fall(cas_fall), .we_fall(we_fall)
  );

  edo_cycle_ctl #(.ADDR_W(ADDR_W), .REF_W(REF_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .we_fall(we_fall), .oe_q(oe_q), .cyc_q(cyc_q),
    .rfsh_row(rfsh_row), .row_q(row_q), .wr_col(wr_col), .wr_en(wr_en),
    .rd_load(rd_load), .clr_all(clr_all)
  );

  edo_array #(.IDX_W(IDX_W), .LANES(LANES)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_idx({row_q, wr_col}), .wr_data(din),
    .rd_idx({row_q, addr}), .rd_data(rd_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edo_out_lane u_lane (
      .clk(clk), .rst_n(rst_n), .load(rd_load[g]), .clr(clr_all),
      .rd_byte(rd_data[g*8 +: 8]), .ras_n(ras_n), .lane_cas_n(cas_n[g]),
      .oe_q(oe_q), .we_q(we_q), .drive(dq_oe[g]), .byte_q(dout[g*8 +: 8])
    );
  end

  assign cyc_type = cyc_q;
endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk
  import edo_pkg::*;
#(
  parameter int REF_W = 9,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [LANES-1:0] dq_oe,
  input logic [2:0]       cyc_type,
  input logic [REF_W-1:0] rfsh_row,
  input logic [LANES-1:0] wr_en
);
  // R6
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> ($past(oe_n) == 1'b0 && $past(we_n) == 1'b1));

  // R2
  early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'(CT_EWR)) |-> (dq_oe == '0));

  // R8
  write_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> (!ras_n && cas_n != '1));

  // R10
  cbr_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) && !ras_n && cas_n != '1) |=> (cyc_type == 3'(CT_CBR)));

  // R10
  rfsh_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(ras_n) && !ras_n) |=> $stable(rfsh_row));
endmodule

bind edo_dram_ctl edo_dram_chk #(.REF_W(REF_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .cyc_type(cyc_type), .rfsh_row(rfsh_row),
  .wr_en(wr_en)
);

// File: tb/tb_edo_dram_ctl.sv
`timescale 1ns/1ps
module tb_edo_dram_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1;
  logic [1:0]  cas_n = 2'b11;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dq_oe;
  logic [2:0]  cyc_type;
  logic [8:0]  rfsh_row;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [15:0] mem_m [256];
  logic [8:0]  ref_m = '0;

  edo_dram_ctl dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe),
    .cyc_type(cyc_type), .rfsh_row(rfsh_row)
  );

  always #5 clk = ~clk;

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lmask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
    return (old & ~lmask(m)) | (nw & lmask(m));
  endfunction

  // early write of lanes m at (r,c)
  task automatic wr_early(input logic [3:0] r, input logic [3:0] c, input logic [15:0] d, input logic [1:0] m);
    addr = r; ras_n = 1'b0; tick;
    addr = c; din = d; we_n = 1'b0; oe_n = 1'b0; cas_n = ~m; tick;
    check("R2 early write type", cyc_type, 2);
    check("R2 early write bus off", dq_oe, 0);
    mem_m[{r, c}] = merge(mem_m[{r, c}], d, m);
    cas_n = 2'b11; tick;
    check("R2 bus off after cas up", dq_oe, 0);
    we_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; tick;
  endtask

  // read of lanes m at (r,c) with data comparison
  task automatic rd_word(input logic [3:0] r, input logic [3:0] c, input logic [1:0] m);
    addr = r; ras_n = 1'b0; tick;
    addr = c; oe_n = 1'b0; cas_n = ~m; tick;
    check("R1 read type", cyc_type, 1);
    check("R5 lane enables", dq_oe, m);
    check("R1 read data", dout & lmask(m), mem_m[{r, c}] & lmask(m));
    cas_n = 2'b11; ras_n = 1'b1; tick;
    check("R7 released when strobes high", dq_oe, 0);
    oe_n = 1'b1; tick;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [15:0] v;
    logic [8:0] start;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick;
    // R12 reset state
    check("R12 reset type", cyc_type, 0);
    check("R12 reset oe", dq_oe, 0);
    check("R12 reset rfsh_row", rfsh_row, 0);

    // fill array with page-mode early writes
    for (int r = 0; r < 16; r++) begin
      addr = 4'(r); ras_n = 1'b0; tick;
      we_n = 1'b0;
      for (int c = 0; c < 16; c++) begin
        v = 16'($urandom);
        addr = 4'(c); din = v; cas_n = 2'b00; tick;
        mem_m[{4'(r), 4'(c)}] = v;
        if (c == 0) check("R2 page early write type", cyc_type, 2);
        cas_n = 2'b11; tick;
      end
      we_n = 1'b1; ras_n = 1'b1; tick;
    end
    rd_word(4'd3, 4'd7, 2'b11);

    // R5 single-lane read and write
    rd_word(4'd5, 4'd2, 2'b01);
    rd_word(4'd5, 4'd2, 2'b10);
    wr_early(4'd5, 4'd2, 16'hA55A, 2'b10);
    rd_word(4'd5, 4'd2, 2'b11);

    // R3 late write with OE high
    addr = 4'd9; ras_n = 1'b0; tick;
    addr = 4'd4; cas_n = 2'b00; tick;
    check("R3 read phase type", cyc_type, 1);
    check("R6 oe high bus off", dq_oe, 0);
    addr = 4'd0; din = 16'h1234; we_n = 1'b0; tick;
    check("R3 late write type", cyc_type, 3);
    mem_m[{4'd9, 4'd4}] = 16'h1234;
    cas_n = 2'b11; we_n = 1'b1; ras_n = 1'b1; tick;
    rd_word(4'd9, 4'd4, 2'b11);

    // R4 read-modify-write, lower lane only
    addr = 4'd10; ras_n = 1'b0; oe_n = 1'b0; tick;
    addr = 4'd11; cas_n = 2'b10; tick;
    check("R4 old data driven", dq_oe, 2'b01);
    check("R4 old data value", dout[7:0], mem_m[{4'd10, 4'd11}][7:0]);
    din = 16'hBEEF; we_n = 1'b0; tick;
    check("R4 rmw type", cyc_type, 4);
    check("R4 bus off after we fall", dq_oe, 0);
    mem_m[{4'd10, 4'd11}] = merge(mem_m[{4'd10, 4'd11}], 16'hBEEF, 2'b01);
    oe_n = 1'b1; cas_n = 2'b11; we_n = 1'b1; ras_n = 1'b1; tick;
    rd_word(4'd10, 4'd11, 2'b11);

    // R6 OE toggle keeps latch
    addr = 4'd1; ras_n = 1'b0; tick;
    addr = 4'd6; oe_n = 1'b0; cas_n = 2'b00; tick;
    oe_n = 1'b1; tick;
    check("R6 oe high disables", dq_oe, 0);
    oe_n = 1'b0; tick;
    check("R6 latch kept enables", dq_oe, 3);
    check("R6 latch kept data", dout, mem_m[{4'd1, 4'd6}]);

    // R7 EDO page hold then next column
    cas_n = 2'b11; addr = 4'd8; tick;
    check("R7 hold after cas up", dq_oe, 3);
    check("R7 hold data", dout, mem_m[{4'd1, 4'd6}]);
    cas_n = 2'b00; tick;
    check("R7 next column data", dout, mem_m[{4'd1, 4'd8}]);
    cas_n = 2'b11; ras_n = 1'b1; tick;
    check("R7 hi-z with both high", dq_oe, 0);
    oe_n = 1'b1; tick;

    // R8 CAS-only with WE low: no write, no drive
    addr = 4'd8; din = 16'h0F0F; we_n = 1'b0; oe_n = 1'b0; cas_n = 2'b00; tick;
    check("R8 cas-only type", cyc_type, 7);
    check("R8 cas-only bus off", dq_oe, 0);
    cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1; tick;
    rd_word(4'd1, 4'd8, 2'b11);

    // R9 RAS-only refresh
    addr = 4'd13; oe_n = 1'b0; ras_n = 1'b0; tick;
    check("R9 ras-only type", cyc_type, 5);
    check("R9 ras-only row", rfsh_row, 13);
    check("R9 ras-only bus off", dq_oe, 0);
    ras_n = 1'b1; oe_n = 1'b1; tick;

    // R10 hidden refresh keeps output
    addr = 4'd2; ras_n = 1'b0; tick;
    addr = 4'd12; oe_n = 1'b0; cas_n = 2'b00; tick;
    ras_n = 1'b1; tick;
    check("R10 hold before cbr", dq_oe, 3);
    addr = 4'd15; ras_n = 1'b0; tick;
    check("R10 cbr type", cyc_type, 6);
    check("R10 cbr row from counter", rfsh_row, ref_m);
    check("R10 output kept", dq_oe, 3);
    check("R10 data kept", dout, mem_m[{4'd2, 4'd12}]);
    ras_n = 1'b1; tick;
    ref_m++;
    cas_n = 2'b11; oe_n = 1'b1; tick;

    // R11 counter advance and wrap
    start = ref_m;
    for (int k = 0; k < 513; k++) begin
      cas_n = 2'b00; tick;
      addr = 4'($urandom); ras_n = 1'b0; tick;
      if (k == 0) check("R11 counter advanced", rfsh_row, 1);
      if (k == 512) check("R11 counter wrapped", rfsh_row, start);
      ras_n = 1'b1; tick;
      ref_m++;
      cas_n = 2'b11; tick;
    end

    // random early writes and reads
    for (int k = 0; k < 80; k++) begin
      logic [3:0] r, c;
      logic [1:0] m;
      r = 4'($urandom); c = 4'($urandom);
      m = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 1) == 1) wr_early(r, c, 16'($urandom), m);
      else rd_word(r, c, m);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule